// File: doc/BRIEF.md
# SHA-256 Streaming Message Padder and Schedule Generator

This block sits in front of a SHA-256 round engine. It takes a message as a stream of 32-bit words over a valid/ready handshake. The final word carries an end flag and a count of the bytes in it that are valid. The block packs the words into 512-bit blocks of sixteen words and appends the standard SHA-256 padding. For each block it then sends the 64 message-schedule words to the round engine in order, one per cycle, over a second valid/ready handshake.

Padding and schedule expansion share one stage. A single 16-word register window holds the block. Schedule words 16 to 63 are computed from taps into that window, and each new word overwrites the word sixteen positions older. When the padding marker and the 64-bit length do not both fit in the last data block, the block builds one extra block that holds only padding and the length. A block takes 16 cycles to fill and 64 cycles to emit, plus any stall cycles.

Top module: `sha256_pad_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `in_ready` is 1 and `w_valid` is 0. A reset in the middle of a message drops that message.
- R2: Schedule words 0 to 15 of a block are the block's words in big-endian byte order. The first message byte of each word occupies bits 31:24.
- R3: Schedule word t, for 16 ≤ t ≤ 63, equals s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] modulo 2^32. Here s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R4: On the word flagged `in_last`, `in_bytes` (1 to 4) gives how many of its upper bytes are message data. The byte 0x80 follows the last message byte. The unused lower bytes of that word are ignored and replaced by 0x80 or zero, whatever they held.
- R5: In the final block, words 14 and 15 hold the message length in bits as a 64-bit big-endian value: high half in word 14, low half in word 15. Every word between the marker and the length is zero.
- R6: If the 0x80 byte lands in word 14 or 15, or past the end of the block, one extra block is produced. It holds zeros (the marker too when it did not fit) and the length. No other blocks are produced.
- R7: `w_blk_last` is 1 on schedule word 63 of every block and 0 on all other words.
- R8: `w_msg_end` is 1 on every word of a message's final block and 0 on every word of the earlier blocks.
- R9: While a block is being emitted or padded, `in_ready` is 0 and input words are not taken. A source that holds its word loses nothing.
- R10: While `w_valid` is 1 and `w_ready` is 0, `w_valid`, `w_data`, `w_blk_last` and `w_msg_end` hold their values.
- R11: After the last word of a final block is taken, `in_ready` is 1 on the next cycle. The next message's length count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message word is offered |
| in_ready | output | 1 | Block accepts a message word this cycle |
| in_word | input | 32 | Message word, big-endian bytes |
| in_last | input | 1 | This word ends the message |
| in_bytes | input | 3 | Valid bytes in the final word, 1 to 4 |
| w_valid | output | 1 | Schedule word is offered |
| w_ready | input | 1 | Round engine takes the schedule word |
| w_data | output | 32 | Schedule word W[t] |
| w_blk_last | output | 1 | Word 63 of the current block |
| w_msg_end | output | 1 | Word belongs to the message's final block |

## Verification
The window is overwritten in place. A wrong tap offset or a write-back to the wrong slot corrupts schedule words from word 16 on, and every later word of that block differs too. A fault in the padding flags shows in the first block that follows. A marker that is lost or duplicated, or a length in the wrong word, changes words 14 and 15 or the number of blocks. In the second case `w_msg_end` and `w_blk_last` then appear on the wrong block, within 80 cycles. A length counter that is not cleared shows in word 15 of the next message.

// File: rtl/sha256_ps_pkg.sv
package sha256_ps_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int SCHED_LEN = 64;
    localparam int LEN_W     = 64;
    localparam int LANES     = WORD_W / 8;
    localparam int IDX_W     = $clog2(BLK_WORDS);
    localparam int T_W       = $clog2(SCHED_LEN);
    localparam int BYTES_W   = $clog2(LANES) + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_PAD  = 2'd1,
        ST_EMIT = 2'd2
    } ps_state_e;

    typedef struct packed {
        ps_state_e                         st;
        logic [IDX_W-1:0]                  idx;
        logic [T_W-1:0]                    t;
        logic [LEN_W-1:0]                  bits;
        logic                              mark;
        logic                              pad;
        logic                              fin;
        logic [BLK_WORDS-1:0][WORD_W-1:0]  win;
    } ps_reg_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t ssig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t ssig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/ps_pad_word.sv
module ps_pad_word
    import sha256_ps_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic               last_i,
    input  logic [BYTES_W-1:0] nbytes_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               mark_next_o
);

    // Lane 0 is the most significant byte (first message byte).
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic keep;
        logic marker;
        assign keep   = !last_i || (BYTES_W'(k) < nbytes_i);
        assign marker = last_i && (BYTES_W'(k) == nbytes_i);
        assign word_o[WORD_W-1-8*k -: 8] = keep   ? word_i[WORD_W-1-8*k -: 8] :
                                           marker ? 8'h80 : 8'h00;
    end

    // A full final word leaves the marker for the following word.
    assign mark_next_o = last_i && (nbytes_i == BYTES_W'(LANES));

endmodule

// File: rtl/ps_expand.sv
module ps_expand
    import sha256_ps_pkg::*;
(
    input  logic [WORD_W-1:0] m2_i,
    input  logic [WORD_W-1:0] m7_i,
    input  logic [WORD_W-1:0] m15_i,
    input  logic [WORD_W-1:0] m16_i,
    output logic [WORD_W-1:0] w_o
);

    assign w_o = ssig1(m2_i) + m7_i + ssig0(m15_i) + m16_i;

endmodule

// File: rtl/sha256_pad_sched.sv
module sha256_pad_sched
    import sha256_ps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_last,
    input  logic [BYTES_W-1:0] in_bytes,
    output logic               w_valid,
    input  logic               w_ready,
    output logic [WORD_W-1:0]  w_data,
    output logic               w_blk_last,
    output logic               w_msg_end
);

    localparam word_t          MARK_WORD = {1'b1, {(WORD_W-1){1'b0}}};
    localparam [IDX_W-1:0]     IDX_HI    = IDX_W'(BLK_WORDS - 2);
    localparam [IDX_W-1:0]     IDX_LO    = IDX_W'(BLK_WORDS - 1);
    localparam [T_W-1:0]       T_LAST    = T_W'(SCHED_LEN - 1);
    localparam [T_W-1:0]       T_COPY    = T_W'(BLK_WORDS);

    localparam ps_reg_t RST_VAL = '{
        st:   ST_FILL,
        idx:  '0,
        t:    '0,
        bits: '0,
        mark: 1'b0,
        pad:  1'b0,
        fin:  1'b0,
        win:  '0
    };

    ps_reg_t q, d;

    word_t            padded_word;
    logic             mark_after;
    word_t            exp_word;
    word_t            pad_val;
    word_t            emit_word;
    logic [IDX_W-1:0] tix;
    logic [LEN_W-1:0] add_bits;

    ps_pad_word u_pad (
        .word_i      (in_word),
        .last_i      (in_last),
        .nbytes_i    (in_bytes),
        .word_o      (padded_word),
        .mark_next_o (mark_after)
    );

    assign tix = q.t[IDX_W-1:0];

    ps_expand u_exp (
        .m2_i  (q.win[tix - IDX_W'(2)]),
        .m7_i  (q.win[tix - IDX_W'(7)]),
        .m15_i (q.win[tix - IDX_W'(15)]),
        .m16_i (q.win[tix]),
        .w_o   (exp_word)
    );

    assign emit_word  = (q.t < T_COPY) ? q.win[tix] : exp_word;
    assign in_ready   = (q.st == ST_FILL);
    assign w_valid    = (q.st == ST_EMIT);
    assign w_data     = emit_word;
    assign w_blk_last = w_valid && (q.t == T_LAST);
    assign w_msg_end  = w_valid && q.fin;

    always_comb begin
        d = q;

        add_bits = in_last ? {{(LEN_W-BYTES_W-3){1'b0}}, in_bytes, 3'b000}
                           : LEN_W'(WORD_W);

        if (q.mark)
            pad_val = MARK_WORD;
        else if (q.idx == IDX_HI)
            pad_val = q.bits[LEN_W-1:WORD_W];
        else if (q.idx == IDX_LO && q.fin)
            pad_val = q.bits[WORD_W-1:0];
        else
            pad_val = '0;

        case (q.st)
            ST_FILL: begin
                if (in_valid) begin
                    d.win[q.idx] = padded_word;
                    d.bits       = q.bits + add_bits;
                    d.idx        = q.idx + IDX_W'(1);
                    if (in_last) begin
                        d.pad  = 1'b1;
                        d.mark = mark_after;
                    end
                    if (q.idx == IDX_LO)
                        d.st = ST_EMIT;
                    else if (in_last)
                        d.st = ST_PAD;
                end
            end
            ST_PAD: begin
                d.win[q.idx] = pad_val;
                if (q.mark)
                    d.mark = 1'b0;
                else if (q.idx == IDX_HI)
                    d.fin = 1'b1;
                d.idx = q.idx + IDX_W'(1);
                if (q.idx == IDX_LO)
                    d.st = ST_EMIT;
            end
            ST_EMIT: begin
                if (w_ready) begin
                    if (q.t >= T_COPY)
                        d.win[tix] = exp_word;
                    d.t = q.t + T_W'(1);
                    if (q.t == T_LAST) begin
                        d.idx = '0;
                        if (q.fin) begin
                            d.st   = ST_FILL;
                            d.fin  = 1'b0;
                            d.pad  = 1'b0;
                            d.mark = 1'b0;
                            d.bits = '0;
                        end else if (q.pad) begin
                            d.st = ST_PAD;
                        end else begin
                            d.st = ST_FILL;
                        end
                    end
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else
            q <= d;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_blk_last) && $stable(w_msg_end)); // R10

    AST_BLOCK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready && w_blk_last |=> !w_valid); // R7

    AST_MSG_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready && w_blk_last && w_msg_end |=> in_ready); // R11

    AST_END_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && $past(w_valid) |-> w_msg_end == $past(w_msg_end)); // R8

    AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |-> in_bytes != '0 && in_bytes <= BYTES_W'(LANES)); // R4

    AST_NO_TAKE_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> !in_ready); // R9

endmodule

// File: tb/sha256_pad_sched_tb.sv
module sha256_pad_sched_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        in_last;
    logic [2:0]  in_bytes;
    logic        w_valid;
    logic        w_ready;
    logic [31:0] w_data;
    logic        w_blk_last;
    logic        w_msg_end;

    always #4 clk = ~clk;

    sha256_pad_sched u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .in_last    (in_last),
        .in_bytes   (in_bytes),
        .w_valid    (w_valid),
        .w_ready    (w_ready),
        .w_data     (w_data),
        .w_blk_last (w_blk_last),
        .w_msg_end  (w_msg_end)
    );

    int checks = 0;
    int errors = 0;
    int pat    = 0;

    localparam int NV = 13;
    localparam int VEC_LEN  [NV] = '{1, 3, 4, 52, 55, 56, 57, 60, 63, 64, 100, 119, 120};
    localparam int VEC_SEED [NV] = '{7, 19, 200, 33, 91, 5, 128, 64, 250, 11, 42, 77, 150};
    localparam int VEC_BLKS [NV] = '{1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 2, 2, 3};

    logic [7:0]  msg_b [0:191];
    logic [31:0] exp_w [0:191];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [7:0] pbyte(input int i, input int len, input int nb);
        logic [63:0] bl;
        int          base;
        bl   = 64'(len) * 64'd8;
        base = nb * 64 - 8;
        if (i < len)       return msg_b[i];
        else if (i == len) return 8'h80;
        else if (i >= base) return bl[8*(7-(i-base)) +: 8];
        else               return 8'h00;
    endfunction

    task automatic build(input int len, input int seed, input int nb);
        logic [31:0] w [0:63];
        for (int i = 0; i < 192; i++) msg_b[i] = 8'((seed + i * 37 + (i >> 3)) & 255);
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 16; k++)
                w[k] = {pbyte(64*b+4*k, len, nb), pbyte(64*b+4*k+1, len, nb),
                        pbyte(64*b+4*k+2, len, nb), pbyte(64*b+4*k+3, len, nb)};
            for (int t = 16; t < 64; t++)
                w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7] +
                       (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
            for (int t = 0; t < 64; t++) exp_w[64*b+t] = w[t];
        end
    endtask

    // Sends up to maxw words of a len-byte message, with idle gaps and junk in unused bytes.
    task automatic send(input int len, input int maxw);
        int nw;
        nw = (len + 3) / 4;
        for (int k = 0; k < nw && k < maxw; k++) begin
            if (k % 5 == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_word  = 32'hDEAD_BEEF;
                in_last  = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (k == nw - 1);
            in_bytes = (k == nw - 1) ? 3'(len - 4 * k) : 3'd4;
            for (int j = 0; j < 4; j++)
                in_word[31-8*j -: 8] = (4*k + j < len) ? msg_b[4*k+j] : 8'hA5;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv(input int nb);
        bit          prev_stall;
        logic [31:0] prev_data;
        int          t;
        prev_stall = 1'b0;
        prev_data  = '0;
        for (int j = 0; j < nb * 64; j++) begin
            t = j % 64;
            forever begin
                @(negedge clk);
                w_ready = ((pat % 7) != 2);
                pat++;
                #1;
                if (prev_stall)
                    chk(w_valid && w_data == prev_data, "R10 hold under stall", 64'(w_data), 64'(prev_data));
                if (w_valid)
                    chk(!in_ready, "R9 input closed while emitting", 64'(in_ready), 64'd0);
                prev_stall = w_valid && !w_ready;
                prev_data  = w_data;
                if (w_valid && w_ready) break;
            end
            if (t >= 16)
                chk(w_data == exp_w[j], "R3 expanded word", 64'(w_data), 64'(exp_w[j]));
            else if (t >= 14 && j / 64 == nb - 1)
                chk(w_data == exp_w[j], "R5 length word", 64'(w_data), 64'(exp_w[j]));
            else
                chk(w_data == exp_w[j], "R2/R4 block word", 64'(w_data), 64'(exp_w[j]));
            chk(w_blk_last == (t == 63), "R7 block last flag", 64'(w_blk_last), 64'(t == 63));
            chk(w_msg_end == (j / 64 == nb - 1), "R8 message end flag", 64'(w_msg_end), 64'(j / 64 == nb - 1));
        end
        @(negedge clk);
        w_ready = 1'b1;
        #1;
        chk(in_ready && !w_valid, "R6/R11 no extra block, ready for next", {62'd0, in_ready, w_valid}, 64'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_word  = '0;
        in_last  = 1'b0;
        in_bytes = 3'd4;
        w_ready  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !w_valid, "R1 reset state", {62'd0, in_ready, w_valid}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !w_valid, "R1 first cycle after reset", {62'd0, in_ready, w_valid}, 64'd2);

        // Table of message lengths: padding boundaries, extra-block cases, multi-block.
        for (int v = 0; v < NV; v++) begin
            chk((VEC_LEN[v] + 8) / 64 + 1 == VEC_BLKS[v], "R6 table block count",
                64'((VEC_LEN[v] + 8) / 64 + 1), 64'(VEC_BLKS[v]));
            build(VEC_LEN[v], VEC_SEED[v], VEC_BLKS[v]);
            fork
                send(VEC_LEN[v], 64);
                recv(VEC_BLKS[v]);
            join
        end

        // Reset in the middle of a message while a block waits to be taken.
        build(100, 3, 2);
        w_ready = 1'b0;
        send(100, 16);
        repeat (4) @(negedge clk);
        #1;
        chk(w_valid && !in_ready, "R9 emitting block holds input closed", {62'd0, w_valid, in_ready}, 64'd2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(in_ready && !w_valid, "R1 mid-message reset", {62'd0, in_ready, w_valid}, 64'd2);
        rst_n = 1'b1;

        // Fresh short message after reset: length must start from zero.
        build(5, 99, 1);
        fork
            send(5, 64);
            recv(1);
        join

        // Two messages back to back without reset (R11).
        build(9, 21, 1);
        fork
            send(9, 64);
            recv(1);
        join
        build(2, 61, 1);
        fork
            send(2, 64);
            recv(1);
        join

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule